// File: doc/BRIEF.md
# Small Multicycle Register Processor

A compact processor with separate program and data spaces. Sixteen-bit instruction words are read from a read-only program memory. A separate RAM holds the data words. Sixteen 32-bit general registers feed an arithmetic/logic unit and a one-bit shifter. A write-back selector chooses what goes back into the register file: the computed value, the RAM read data, or an immediate taken from program memory.

There are no condition flags. A branch depends on an explicit sign-test instruction that writes 0 or 1 into a register. A jump instruction then branches when a chosen register is non-zero. Every instruction passes through fetch, decode, execute and write-back. On a halt, the program counter freezes and the chosen register appears on the result bus. Before the halt, the result bus is left undriven, so a testbench or board can wait for the halted flag and then read the answer.

The program and data memories sit outside the block and are read combinationally: the read word for the address presented is valid in the same cycle. RAM writes take effect at the clock edge while the write strobe is high.

Top module: `mcpu_top`

## Requirements
- R1: While reset is low: the program address is 0, halted is low, the result bus is high impedance, and all registers are zero.
- R2: Instruction word fields: bits [15:12] hold the opcode, bits [11:8] hold register X, and bits [7:4] hold register Y. Bits [3:0] are ignored. Opcodes: 0 load-immediate, 1 load-RAM, 2 store-RAM, 3 add, 4 subtract, 5 AND, 6 OR, 7 XOR, 8 shift-right, 9 shift-left, A sign-test, B jump-if-non-zero, C halt.
- R3: Each non-halt instruction takes exactly 4 clock cycles. Halted rises 2 cycles after a halt instruction is fetched. A run of N non-halt instructions ending in a halt therefore takes 4N+2 cycles from reset release to halted.
- R4: Load-immediate writes the next program word, sign-extended to 32 bits, into X. Execution then continues after that word.
- R5: Add, subtract, AND, OR and XOR compute X = X op Y. Add and subtract wrap modulo 2^32.
- R6: Shift-right writes Y shifted right by one bit into X, and shift-left writes Y shifted left by one bit into X. The vacated bit is zero in both cases.
- R7: Load-RAM writes RAM[Y[7:0]] into X. Store-RAM writes X into RAM[Y[7:0]]. The write strobe is high for exactly one cycle per store, and only stores raise it.
- R8: Sign-test writes 1 into X when bit 31 of Y is set, and writes 0 otherwise.
- R9: Jump-if-non-zero reads an absolute target from the next program word. It jumps there when X is non-zero, and otherwise continues after that word.
- R10: Halt X raises halted and freezes the program address. It drives X onto the result bus, and all of this holds until reset.
- R11: The result bus stays high impedance until halted is high.
- R12: Opcodes D, E and F change no register and no RAM word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pm_addr | output | 8 | Program memory word address |
| pm_data | input | 16 | Program memory word at pm_addr |
| ram_addr | output | 8 | Data RAM word address |
| ram_wdata | output | 32 | Data RAM write word |
| ram_rdata | input | 32 | Data RAM word at ram_addr |
| ram_we | output | 1 | Data RAM write strobe |
| result | output | 32 | Result bus, high impedance until halt |
| halted | output | 1 | Processor has executed halt |

## Verification
On every cycle, the embedded assertions check the state sequencing: write-back is always followed by fetch, and a halt can only be entered from decode. They also check that halted never drops once raised, that the program address stays frozen while halted, and that the RAM write strobe lasts a single cycle. Data-path results cannot be seen by those properties. These results are sign extension, zero-filled shifts, modular arithmetic, loads and stores, taken and untaken branches, and the inertness of spare opcodes. The bench shows them by running directed programs and seeded random programs, then comparing the result bus, RAM contents and cycle counts against an instruction-level model.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    typedef enum logic [3:0] {
        OP_LDI  = 4'h0,
        OP_LDM  = 4'h1,
        OP_STM  = 4'h2,
        OP_ADD  = 4'h3,
        OP_SUB  = 4'h4,
        OP_AND  = 4'h5,
        OP_OR   = 4'h6,
        OP_XOR  = 4'h7,
        OP_SHR  = 4'h8,
        OP_SHL  = 4'h9,
        OP_SGN  = 4'hA,
        OP_JNZ  = 4'hB,
        OP_HALT = 4'hC,
        OP_RSVD = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WB,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        WB_ALU,
        WB_RAM,
        WB_IMM
    } wbsel_e;

    function automatic logic op_writes_reg(input logic [3:0] op);
        return (op <= 4'hA) && (op != 4'h2);
    endfunction

    function automatic wbsel_e op_wbsel(input logic [3:0] op);
        case (op)
            4'h0:    return WB_IMM;
            4'h1:    return WB_RAM;
            default: return WB_ALU;
        endcase
    endfunction

endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter int DW  = 32,
    parameter int AW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data
);
    localparam int NREG = 2 ** AW;

    logic [DW-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_en && (wr_idx == AW'(g))) begin
                regs_q[g] <= wr_data;
            end
        end
    end

    assign rd_a = regs_q[rd_a_idx];
    assign rd_b = regs_q[rd_b_idx];

endmodule

// File: rtl/mcpu_shift.sv
module mcpu_shift #(
    parameter int DW = 32
) (
    input  logic          left,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_comb begin
        if (left) begin
            dout = {din[DW-2:0], 1'b0};
        end else begin
            dout = {1'b0, din[DW-1:1]};
        end
    end
endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] z
);
    logic [DW-1:0] shifted;

    mcpu_shift #(.DW(DW)) shift_i (
        .left (op == OP_SHL),
        .din  (y),
        .dout (shifted)
    );

    always_comb begin
        case (op)
            OP_ADD:         z = x + y;
            OP_SUB:         z = x - y;
            OP_AND:         z = x & y;
            OP_OR:          z = x | y;
            OP_XOR:         z = x ^ y;
            OP_SHR, OP_SHL: z = shifted;
            OP_SGN:         z = DW'(y[DW-1]);
            default:        z = x;
        endcase
    end
endmodule

// File: rtl/mcpu_wbmux.sv
module mcpu_wbmux
    import mcpu_pkg::*;
#(
    parameter int DW = 32
) (
    input  wbsel_e        sel,
    input  logic [DW-1:0] alu_val,
    input  logic [DW-1:0] ram_val,
    input  logic [DW-1:0] imm_val,
    output logic [DW-1:0] dout
);
    always_comb begin
        case (sel)
            WB_RAM:  dout = ram_val;
            WB_IMM:  dout = imm_val;
            default: dout = alu_val;
        endcase
    end
endmodule

// File: rtl/mcpu_top.sv
module mcpu_top
    import mcpu_pkg::*;
#(
    parameter int DW  = 32,
    parameter int IW  = 16,
    parameter int PAW = 8,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [PAW-1:0] pm_addr,
    input  logic [IW-1:0]  pm_data,
    output logic [RAW-1:0] ram_addr,
    output logic [DW-1:0]  ram_wdata,
    input  logic [DW-1:0]  ram_rdata,
    output logic           ram_we,
    output wire  [DW-1:0]  result,
    output logic           halted
);
    localparam int RFW = 4;
    localparam int OPW = 4;

    typedef struct packed {
        state_e         st;
        logic [PAW-1:0] pc;
        logic [IW-1:0]  ir;
        logic [IW-1:0]  imm;
        logic [DW-1:0]  res;
    } core_s;

    core_s cur_q, nxt_d;

    logic [OPW-1:0] op;
    logic [RFW-1:0] x_idx, y_idx;
    logic [DW-1:0]  x_val, y_val, alu_val, wb_val, imm_ext;

    assign op      = cur_q.ir[IW-1 -: OPW];
    assign x_idx   = cur_q.ir[IW-OPW-1 -: RFW];
    assign y_idx   = cur_q.ir[IW-OPW-RFW-1 -: RFW];
    assign imm_ext = {{(DW-IW){cur_q.imm[IW-1]}}, cur_q.imm};

    mcpu_regfile #(.DW(DW), .AW(RFW)) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (x_idx),
        .rd_b_idx (y_idx),
        .rd_a     (x_val),
        .rd_b     (y_val),
        .wr_en    ((cur_q.st == ST_WB) && op_writes_reg(op)),
        .wr_idx   (x_idx),
        .wr_data  (cur_q.res)
    );

    mcpu_alu #(.DW(DW)) alu_i (
        .op (op),
        .x  (x_val),
        .y  (y_val),
        .z  (alu_val)
    );

    mcpu_wbmux #(.DW(DW)) wbmux_i (
        .sel     (op_wbsel(op)),
        .alu_val (alu_val),
        .ram_val (ram_rdata),
        .imm_val (imm_ext),
        .dout    (wb_val)
    );

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ST_FETCH: begin
                nxt_d.ir = pm_data;
                nxt_d.pc = cur_q.pc + 1'b1;
                nxt_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                if (op == OP_HALT) begin
                    nxt_d.st = ST_HALT;
                end else begin
                    nxt_d.st = ST_EXEC;
                    if (op == OP_LDI || op == OP_JNZ) begin
                        nxt_d.imm = pm_data;
                        nxt_d.pc  = cur_q.pc + 1'b1;
                    end
                end
            end
            ST_EXEC: begin
                nxt_d.res = wb_val;
                if (op == OP_JNZ && x_val != '0) begin
                    nxt_d.pc = cur_q.imm[PAW-1:0];
                end
                nxt_d.st = ST_WB;
            end
            ST_WB:   nxt_d.st = ST_FETCH;
            default: nxt_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_FETCH, pc: '0, ir: '0, imm: '0, res: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pm_addr   = cur_q.pc;
    assign ram_addr  = y_val[RAW-1:0];
    assign ram_wdata = x_val;
    assign ram_we    = (cur_q.st == ST_EXEC) && (op == OP_STM);
    assign halted    = (cur_q.st == ST_HALT);
    assign result    = halted ? x_val : {DW{1'bz}};

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R10
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pm_addr)); // R10
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we); // R7
    AST_WB_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_WB) |=> (cur_q.st == ST_FETCH)); // R3
    AST_HALT_FROM_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> ($past(cur_q.st) == ST_DECODE)); // R3

endmodule

// File: tb/mcpu_top_tb_top.sv
module mcpu_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int MAXCYC = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  pm_addr, ram_addr;
    logic [15:0] pm_data;
    logic [31:0] ram_wdata, ram_rdata;
    logic        ram_we, halted;
    tri1  [31:0] res_bus;

    logic [15:0] rom [256];
    logic [31:0] ram [256];
    logic [31:0] init_mem [256];
    logic [31:0] mram [256];
    logic [31:0] mreg [16];
    logic        init_req = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles_total = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcpu_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pm_addr   (pm_addr),
        .pm_data   (pm_data),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .result    (res_bus),
        .halted    (halted)
    );

    assign pm_data   = rom[pm_addr];
    assign ram_rdata = ram[ram_addr];

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < 256; i++) ram[i] <= init_mem[i];
        end else if (ram_we) begin
            ram[ram_addr] <= ram_wdata;
        end
    end

    always @(posedge clk) begin
        cycles_total <= cycles_total + 1;
        if (cycles_total > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [3:0] x, input logic [3:0] y);
        return {op, x, y, 4'h0};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            rom[i] = ins(4'hC, 4'h0, 4'h0);
            init_mem[i] = 32'h0;
        end
    endtask

    task automatic model_run(output logic [31:0] res, output int cyc);
        logic [7:0] pc;
        logic [15:0] w, t;
        logic [3:0] op, x, y;
        for (int i = 0; i < 16; i++) mreg[i] = 32'h0;
        for (int i = 0; i < 256; i++) mram[i] = init_mem[i];
        pc = 8'h0; cyc = 0; res = 32'h0;
        for (int s = 0; s < 1000; s++) begin
            w = rom[pc]; op = w[15:12]; x = w[11:8]; y = w[7:4]; pc = pc + 8'd1;
            if (op == 4'hC) begin
                res = mreg[x]; cyc += 2; break;
            end
            cyc += 4;
            case (op)
                4'h0: begin mreg[x] = {{16{rom[pc][15]}}, rom[pc]}; pc = pc + 8'd1; end
                4'h1: mreg[x] = mram[mreg[y][7:0]];
                4'h2: mram[mreg[y][7:0]] = mreg[x];
                4'h3: mreg[x] = mreg[x] + mreg[y];
                4'h4: mreg[x] = mreg[x] - mreg[y];
                4'h5: mreg[x] = mreg[x] & mreg[y];
                4'h6: mreg[x] = mreg[x] | mreg[y];
                4'h7: mreg[x] = mreg[x] ^ mreg[y];
                4'h8: mreg[x] = mreg[y] >> 1;
                4'h9: mreg[x] = mreg[y] << 1;
                4'hA: mreg[x] = {31'h0, mreg[y][31]};
                4'hB: begin t = rom[pc]; pc = pc + 8'd1; if (mreg[x] != 0) pc = t[7:0]; end
                default: ;
            endcase
        end
    endtask

    // Reset, check reset state, run to halt; returns cycles from release to halted
    task automatic run_dut(output int cyc);
        @(negedge clk);
        rst_n = 1'b0; init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        @(negedge clk);
        chk(halted == 1'b0, "R1 halted in reset", {31'h0, halted}, 32'h0);
        chk(pm_addr == 8'h0, "R1 pc in reset", {24'h0, pm_addr}, 32'h0);
        chk(res_bus == 32'hFFFF_FFFF, "R1 result undriven in reset", res_bus, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        cyc = 0;
        while (cyc < MAXCYC) begin
            @(posedge clk); #1;
            cyc++;
            if (cyc == 3) chk(res_bus == 32'hFFFF_FFFF, "R11 result undriven while running", res_bus, 32'hFFFF_FFFF);
            if (halted) break;
        end
        chk(halted == 1'b1, "R10 halted reached", {31'h0, halted}, 32'h1);
        @(negedge clk);
    endtask

    task automatic compare_all(input string tag);
        logic [31:0] mres;
        int mcyc, dcyc;
        model_run(mres, mcyc);
        run_dut(dcyc);
        chk(res_bus == mres, {tag, " result"}, res_bus, mres);
        chk(dcyc == mcyc, {"R3 cycles ", tag}, dcyc, mcyc);
        for (int i = 0; i < 256; i++) begin
            if (ram[i] != mram[i]) begin
                chk(1'b0, {"R7 ram ", tag}, ram[i], mram[i]);
                break;
            end
        end
    endtask

    initial begin
        logic [7:0] p;
        logic [31:0] hold;
        logic [7:0] pc_hold;
        int dcyc;
        int r;
        void'($urandom(32'd1234));

        // R9 R5 R3: loop multiply 6*7 by repeated add, 24 instr + halt = 98 cycles
        clear_mem();
        rom[0] = ins(4'h0, 4'h1, 4'h0); rom[1] = 16'd6;
        rom[2] = ins(4'h0, 4'h2, 4'h0); rom[3] = 16'd7;
        rom[4] = ins(4'h0, 4'h4, 4'h0); rom[5] = 16'd1;
        rom[6] = ins(4'h3, 4'h3, 4'h1);
        rom[7] = ins(4'h4, 4'h2, 4'h4);
        rom[8] = ins(4'hB, 4'h2, 4'h0); rom[9] = 16'd6;
        rom[10] = ins(4'hC, 4'h3, 4'h0);
        run_dut(dcyc);
        chk(res_bus == 32'd42, "R9 R5 loop multiply", res_bus, 32'd42);
        chk(dcyc == 98, "R3 loop cycle count", dcyc, 32'd98);
        // R10: frozen after halt
        hold = res_bus; pc_hold = pm_addr;
        repeat (10) @(negedge clk);
        chk(halted && res_bus == hold, "R10 result held", res_bus, hold);
        chk(pm_addr == pc_hold, "R10 pc frozen", {24'h0, pm_addr}, {24'h0, pc_hold});

        // R8 R9 R4: sign test taken (negative sign-extended immediate) and not taken
        for (int k = 0; k < 2; k++) begin
            clear_mem();
            rom[0] = ins(4'h0, 4'h1, 4'h0); rom[1] = (k == 0) ? 16'hFFFB : 16'h0005;
            rom[2] = ins(4'hA, 4'h2, 4'h1);
            rom[3] = ins(4'hB, 4'h2, 4'h0); rom[4] = 16'd8;
            rom[5] = ins(4'h0, 4'h5, 4'h0); rom[6] = 16'h0011;
            rom[7] = ins(4'hC, 4'h5, 4'h0);
            rom[8] = ins(4'h0, 4'h5, 4'h0); rom[9] = 16'h0022;
            rom[10] = ins(4'hC, 4'h5, 4'h0);
            run_dut(dcyc);
            chk(res_bus == ((k == 0) ? 32'h22 : 32'h11), "R8 R9 sign branch", res_bus, (k == 0) ? 32'h22 : 32'h11);
            clear_mem();
            rom[0] = ins(4'h0, 4'h1, 4'h0); rom[1] = (k == 0) ? 16'hFFFB : 16'h0005;
            rom[2] = ins(4'hC, 4'h1, 4'h0);
            run_dut(dcyc);
            chk(res_bus == ((k == 0) ? 32'hFFFF_FFFB : 32'h5), "R4 sign extension", res_bus, (k == 0) ? 32'hFFFF_FFFB : 32'h5);
        end

        // R7 R12: store, spare opcodes, load back
        clear_mem();
        rom[0] = ins(4'h0, 4'h1, 4'h0); rom[1] = 16'h1234;
        rom[2] = ins(4'h0, 4'h2, 4'h0); rom[3] = 16'h0040;
        rom[4] = {4'hD, 4'h1, 4'h1, 4'hF};
        rom[5] = {4'hE, 4'h1, 4'h2, 4'h3};
        rom[6] = {4'hF, 4'h2, 4'h1, 4'h0};
        rom[7] = ins(4'h2, 4'h1, 4'h2);
        rom[8] = ins(4'h1, 4'h3, 4'h2);
        rom[9] = ins(4'hC, 4'h3, 4'h0);
        run_dut(dcyc);
        chk(res_bus == 32'h1234, "R7 R12 store then load", res_bus, 32'h1234);
        chk(ram[8'h40] == 32'h1234, "R7 ram word written", ram[8'h40], 32'h1234);
        chk(ram[8'h41] == 32'h0, "R7 R12 neighbour untouched", ram[8'h41], 32'h0);

        // R6: shifts with zero fill on an all-ones word
        clear_mem();
        rom[0] = ins(4'h0, 4'h1, 4'h0); rom[1] = 16'hFFFF;
        rom[2] = ins(4'h8, 4'h2, 4'h1);
        rom[3] = ins(4'h9, 4'h3, 4'h1);
        rom[4] = ins(4'h7, 4'h2, 4'h3);
        rom[5] = ins(4'hC, 4'h2, 4'h0);
        run_dut(dcyc);
        chk(res_bus == 32'h8000_0001, "R6 zero fill both ways", res_bus, 32'h8000_0001);

        // R2 R4 R5 R6 R7 R8 R12: seeded random straight-line programs vs model
        for (int n = 0; n < 12; n++) begin
            clear_mem();
            for (int i = 0; i < 256; i++) init_mem[i] = $urandom;
            p = 8'h0;
            for (int i = 0; i < 40; i++) begin
                r = $urandom_range(0, 13);
                rom[p] = {(r <= 10) ? 4'(r) : 4'(r + 2), 4'($urandom), 4'($urandom), 4'($urandom)};
                p = p + 8'd1;
                if (r == 0) begin rom[p] = 16'($urandom); p = p + 8'd1; end
            end
            rom[p] = ins(4'hC, 4'($urandom), 4'h0);
            compare_all("R2 R5 R6 R8 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule